// File: doc/BRIEF.md
# PWM Prescaler and Period Calculator

This block turns a requested PWM frequency, given in hertz, into the settings a timer needs to produce it. The reference clock frequency is fixed by a parameter. From it the block chooses three values:

- a power-of-two prescaler exponent;
- a 16-bit period count;
- a guard count, which tells the timer how early before a compare point a duty-cycle update must land.

It also reports the frequency those settings actually give.

A request starts with a one-cycle `start` pulse that carries `rate_hz`. The block then steps through its calculation with one shared shift-subtract divider, so it needs no divider macro. It answers with a one-cycle `done` pulse, and the results sit on the outputs until the next request finishes. A requested rate of zero cannot be served. It is answered at once with `err` raised alongside `done`.

Top module: `pwmc_calc`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `err` are 0, and `exp_o`, `period_o`, `guard_o` and `actual_hz` are all 0.
- R2: The exponent is chosen by trying n = 0, 1, … 7 in rising order. The block keeps the first n whose rounded period is at most 65535.
- R3: For an exponent n, the candidate period is (REF_HZ + d/2) / d with d = rate_hz × 2^n. This is a division rounded to nearest, so a fraction of one half or more rounds up.
- R4: When no exponent up to 7 yields a period of 65535 or less, the result is forced to exponent 7 with period 65535.
- R5: `guard_o` equals 32 shifted right by the chosen exponent, and is never less than 2.
- R6: When the selected period is below (3 × guard) / 2, with the division truncating, the reported period is guard + 4 instead.
- R7: `actual_hz` equals REF_HZ / (period_o × 2^exp_o), truncated.
- R8: A request with `rate_hz` = 0 gives `done` = 1 and `err` = 1 in the cycle after `start`, with all four result outputs set to 0. A later successful request returns `err` to 0.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. It neither starts a second calculation nor changes the result of the one in progress.
- R10: `done` is high for exactly one cycle per request. The result outputs change only in the cycle in which `done` is high, and they hold even if `rate_hz` changes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request pulse |
| rate_hz | input | 32 | Requested PWM frequency in Hz, sampled with `start` |
| busy | output | 1 | High while a calculation runs |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request was rejected (rate of zero) |
| exp_o | output | 3 | Chosen prescaler exponent (divisor 2^exp_o) |
| period_o | output | 16 | Period count in prescaled ticks |
| guard_o | output | 6 | Guard count in prescaled ticks |
| actual_hz | output | 32 | Frequency achieved by the chosen settings |

## Verification
The rates are picked so that each one stops the exponent search at a different point:
- A mid-range rate fits at exponent 0.
- A low rate needs exponent 2, which shows the search runs in order and stops at the first fit.
- A rate of 1 Hz fits at no exponent and must end in the forced 65535 / 7 result.

One rate has a quotient fraction above one half, so rounding up can be told apart from truncation. A megahertz rate and a rate near the top of the 32-bit range both give periods below the guard threshold, so the minimum-period replacement is exercised, including for a raw quotient of zero. The remaining cases each isolate one control behaviour:
- a zero rate;
- a second start during a calculation;
- a change of `rate_hz` after completion.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int RATE_W     = 32;
    localparam int PER_W      = 16;
    localparam int EXP_W      = 3;
    localparam int GUARD_W    = 6;
    localparam int DIV_W      = 40;
    localparam int EXP_LAST   = (1 << EXP_W) - 1;
    localparam int GUARD_BASE = 32;
    localparam int GUARD_MIN  = 2;
    localparam int PER_MAX    = (1 << PER_W) - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRY_GO,
        ST_TRY_WAIT,
        ST_FIX,
        ST_RATE_GO,
        ST_RATE_WAIT
    } state_e;

    typedef struct packed {
        logic [EXP_W-1:0]   expo;
        logic [PER_W-1:0]   period;
        logic [GUARD_W-1:0] guard;
        logic [RATE_W-1:0]  actual;
    } result_t;

    // Guard count for a given prescaler exponent, with its floor applied
    function automatic logic [GUARD_W-1:0] guard_for(input logic [EXP_W-1:0] e);
        logic [31:0] g;
        g = 32'(GUARD_BASE) >> e;
        if (g < 32'(GUARD_MIN)) g = 32'(GUARD_MIN);
        return GUARD_W'(g);
    endfunction

endpackage

// File: rtl/pwmc_divider.sv
module pwmc_divider #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     q_q;
    logic [W-1:0]     den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    logic [W:0] shifted;
    logic       take;

    always_comb begin
        shifted = {rem_q, q_q[W-1]};
        take    = (shifted >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            q_q    <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                rem_q  <= '0;
                q_q    <= num;
                den_q  <= den;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (take) rem_q <= W'(shifted - {1'b0, den_q});
                else      rem_q <= shifted[W-1:0];
                q_q   <= {q_q[W-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quo  = q_q;

    // R3
    div_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);

endmodule

// File: rtl/pwmc_guard.sv
module pwmc_guard
    import pwmc_pkg::*;
(
    input  logic [EXP_W-1:0]   expo,
    input  logic [PER_W-1:0]   period_raw,
    output logic [GUARD_W-1:0] guard,
    output logic [PER_W-1:0]   period_adj
);
    logic [GUARD_W+1:0] limit;

    always_comb begin
        guard = guard_for(expo);
        limit = ((GUARD_W+2)'(guard) * (GUARD_W+2)'(3)) >> 1;
        if (period_raw < PER_W'(limit))
            period_adj = PER_W'(guard) + PER_W'(4);
        else
            period_adj = period_raw;
    end

    // R5
    always_comb begin
        guard_floor_chk: assert (guard >= GUARD_W'(GUARD_MIN));
    end

endmodule

// File: rtl/pwmc_calc.sv
module pwmc_calc
    import pwmc_pkg::*;
#(
    parameter int unsigned REF_HZ = 24_000_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [RATE_W-1:0]  rate_hz,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [EXP_W-1:0]   exp_o,
    output logic [PER_W-1:0]   period_o,
    output logic [GUARD_W-1:0] guard_o,
    output logic [RATE_W-1:0]  actual_hz
);
    localparam logic [DIV_W-1:0] REF_EXT = DIV_W'(REF_HZ);

    state_e              state_q;
    logic [RATE_W-1:0]   rate_q;
    logic [EXP_W-1:0]    n_q;
    logic [PER_W-1:0]    per_q;
    logic [GUARD_W-1:0]  g_q;
    result_t             res_q;
    logic                done_q;
    logic                err_q;

    logic                div_go;
    logic [DIV_W-1:0]    div_num;
    logic [DIV_W-1:0]    div_den;
    logic                div_busy;
    logic                div_done;
    logic [DIV_W-1:0]    div_quo;
    logic [DIV_W-1:0]    d_try;
    logic                fits;
    logic [GUARD_W-1:0]  g_new;
    logic [PER_W-1:0]    per_new;

    always_comb begin
        d_try  = DIV_W'(rate_q) << n_q;
        div_go = (state_q == ST_TRY_GO) || (state_q == ST_RATE_GO);
        if (state_q == ST_RATE_GO || state_q == ST_RATE_WAIT) begin
            div_num = REF_EXT;
            div_den = DIV_W'(per_q) << n_q;
        end else begin
            div_num = REF_EXT + (d_try >> 1);
            div_den = d_try;
        end
        fits = (div_quo[DIV_W-1:PER_W] == '0);
    end

    pwmc_divider #(.W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .busy (div_busy),
        .done (div_done),
        .quo  (div_quo)
    );

    pwmc_guard u_guard (
        .expo       (n_q),
        .period_raw (per_q),
        .guard      (g_new),
        .period_adj (per_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rate_q  <= '0;
            n_q     <= '0;
            per_q   <= '0;
            g_q     <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (rate_hz == '0) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            res_q  <= '0;
                        end else begin
                            rate_q  <= rate_hz;
                            n_q     <= '0;
                            state_q <= ST_TRY_GO;
                        end
                    end
                end
                ST_TRY_GO: state_q <= ST_TRY_WAIT;
                ST_TRY_WAIT: begin
                    if (div_done) begin
                        if (fits) begin
                            per_q   <= div_quo[PER_W-1:0];
                            state_q <= ST_FIX;
                        end else if (n_q == EXP_W'(EXP_LAST)) begin
                            per_q   <= PER_W'(PER_MAX);
                            state_q <= ST_FIX;
                        end else begin
                            n_q     <= n_q + 1'b1;
                            state_q <= ST_TRY_GO;
                        end
                    end
                end
                ST_FIX: begin
                    per_q   <= per_new;
                    g_q     <= g_new;
                    state_q <= ST_RATE_GO;
                end
                ST_RATE_GO: state_q <= ST_RATE_WAIT;
                ST_RATE_WAIT: begin
                    if (div_done) begin
                        res_q.expo   <= n_q;
                        res_q.period <= per_q;
                        res_q.guard  <= g_q;
                        res_q.actual <= div_quo[RATE_W-1:0];
                        done_q       <= 1'b1;
                        err_q        <= 1'b0;
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign exp_o     = res_q.expo;
    assign period_o  = res_q.period;
    assign guard_o   = res_q.guard;
    assign actual_hz = res_q.actual;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({exp_o, period_o, guard_o, actual_hz, err}));

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (period_o == '0 && actual_hz == '0));

    // R6
    period_min_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> ((32'(period_o) * 2 >= 32'(guard_o) * 3)
                            || (period_o == PER_W'(guard_o) + PER_W'(4))));

    // R9
    div_launch_chk: assert property (@(posedge clk) disable iff (rst)
        div_go |-> !div_busy);

endmodule

// File: tb/sim_pwmc_calc.sv
module sim_pwmc_calc;

    localparam int unsigned REF = 24_000_000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] rate_hz;
    logic        busy;
    logic        done;
    logic        err;
    logic [2:0]  exp_o;
    logic [15:0] period_o;
    logic [5:0]  guard_o;
    logic [31:0] actual_hz;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pwmc_calc #(.REF_HZ(REF)) u0 (
        .clk(clk), .rst(rst), .start(start), .rate_hz(rate_hz),
        .busy(busy), .done(done), .err(err), .exp_o(exp_o),
        .period_o(period_o), .guard_o(guard_o), .actual_hz(actual_hz)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected values from the requirements, in plain integer math
    task automatic model(input longint unsigned rate, output longint e,
                         output longint p, output longint g, output longint a);
        bit found = 0;
        e = 7; p = 65535;
        for (int n = 0; n < 8; n++) begin
            longint unsigned d, q;
            d = rate << n;
            q = (longint'(REF) + d / 2) / d;
            if (!found && q <= 65535) begin
                found = 1; e = n; p = longint'(q);
            end
        end
        g = 32 >> e;
        if (g < 2) g = 2;
        if (p < (3 * g) / 2) p = g + 4;
        a = longint'(REF) / (p << e);
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk({req, " done seen"}, longint'(done), 1);
    endtask

    task automatic run_calc(input longint unsigned rate, input string req);
        longint e, p, g, a;
        model(rate, e, p, g, a);
        @(negedge clk);
        start = 1'b1; rate_hz = 32'(rate);
        @(negedge clk);
        start = 1'b0;
        wait_done(req);
        chk({req, " exp"}, longint'(exp_o), e);
        chk({req, " period"}, longint'(period_o), p);
        chk({req, " guard"}, longint'(guard_o), g);
        chk({req, " actual R7"}, longint'(actual_hz), a);
        chk({req, " err R8"}, longint'(err), 0);
        @(negedge clk);
        chk("R10 done one cycle", longint'(done), 0);
    endtask

    task automatic test_reset();
        chk("R1 busy", longint'(busy), 0);
        chk("R1 done", longint'(done), 0);
        chk("R1 err", longint'(err), 0);
        chk("R1 outputs", longint'({exp_o, period_o, guard_o, actual_hz}), 0);
    endtask

    task automatic test_zero();
        @(negedge clk);
        start = 1'b1; rate_hz = 32'd0;
        @(negedge clk);
        start = 1'b0;
        chk("R8 done", longint'(done), 1);
        chk("R8 err", longint'(err), 1);
        chk("R8 period", longint'(period_o), 0);
        chk("R8 actual", longint'(actual_hz), 0);
        @(negedge clk);
        chk("R8 done one cycle", longint'(done), 0);
    endtask

    task automatic test_busy_start();
        longint e, p, g, a;
        int extra = 0;
        model(100, e, p, g, a);
        @(negedge clk);
        start = 1'b1; rate_hz = 32'd100;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 busy", longint'(busy), 1);
        start = 1'b1; rate_hz = 32'd1000;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9");
        chk("R9 period", longint'(period_o), p);
        chk("R9 exp", longint'(exp_o), e);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R9 no second done", longint'(extra), 0);
        chk("R9 idle", longint'(busy), 0);
    endtask

    task automatic test_hold();
        longint e, p, g, a;
        model(30000, e, p, g, a);
        run_calc(30000, "R10");
        rate_hz = 32'd5;
        repeat (50) @(negedge clk);
        chk("R10 hold period", longint'(period_o), p);
        chk("R10 hold actual", longint'(actual_hz), a);
        chk("R10 hold exp", longint'(exp_o), e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; rate_hz = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_calc(1000, "R2 fit at n0");
        run_calc(100, "R2 fit at n2");
        run_calc(900, "R3 round up");
        run_calc(7, "R3 high exponent");
        run_calc(1, "R4 forced");
        run_calc(5000, "R5 guard");
        run_calc(1_000_000, "R6 min period");
        run_calc(64'd4_000_000_000, "R6 zero quotient");
        test_zero();
        run_calc(2000, "R8 after error");
        test_busy_start();
        test_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule